// File: doc/BRIEF.md
# ADC Sample-Timer and Trigger Controller

This block holds the 16-bit control word of a successive-approximation converter and produces the sample-and-hold timing. A bus write port loads the word and a read port returns it. A conversion begins in one of two ways: software sets the start bit, or a rising edge arrives on the external trigger input. The block then holds `sample_win` high for a programmed number of converter-clock cycles, raises `conv_start` for one cycle, and waits for `conv_done` from the converter.

The sample length comes from one of two 4-bit codes. The code is picked by the result-slot index on `slot_idx` at the moment the window opens. The codes follow a nonlinear scale from 4 to 512 cycles. While the enable bit is set, the timing fields, the repeat bit and the power bit are frozen. When sequence operation is signalled on `seq_mode` and the repeat bit is set, each completed conversion starts the next window without any further trigger. This continues until software clears the enable bit.

Top module: `adc_sample_ctrl`

## Requirements
- R1: After reset, `rd_data` reads 0x0000 and `sample_win` and `conv_start` are low.
- R2: Sample code c gives a window of L cycles, with c→L: 0→4, 1→8, 2→16, 3→32, 4→64, 5→96, 6→128, 7→192, 8→256, 9→384, 10→512. Codes 11 to 15 give 512.
- R3: If `slot_idx` lies in 8..23 when the window opens, the code in bits 15:12 sets the length. Any other slot uses the code in bits 11:8.
- R4: `sample_win` is high for exactly L consecutive cycles. `conv_start` is high for exactly the one cycle after the window. No new window opens until `conv_done` has been seen. Start requests that arrive during that time are discarded.
- R5: While bit 1 (enable) reads 1, a write leaves bits 15:4 unchanged. Bits 1 and 0 stay writable.
- R6: Bits 6:5 and 3:2 always read 0, whatever is written to them.
- R7: Writing 1 to bit 0 (start) reads back 1 for one cycle and then 0. It may be written in the same write that sets enable. It opens a window on the next cycle only if bit 4 (on) and bit 1 (enable) are both 1. Otherwise it has no effect.
- R8: When on and enable are set and the block is idle, a 0→1 transition of `trig_in` opens one window. A level held high opens no further window.
- R9: When bit 7 (repeat) is 1 and `seq_mode` is 1, a window opens in the cycle after `conv_done` without any trigger. If either of the two is 0, the block returns to idle.
- R10: If enable is cleared during a conversion, the conversion still completes, but no further window opens after its `conv_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current control word |
| trig_in | input | 1 | Sample-input trigger; the rising edge is used |
| seq_mode | input | 1 | High when the sequencer runs a sequence or repeat mode |
| slot_idx | input | 5 | Index of the result slot for the next window |
| conv_done | input | 1 | Converter finished the current conversion |
| sample_win | output | 1 | Sample-and-hold window |
| conv_start | output | 1 | One-cycle conversion start |

## Verification
The length table is swept over all sixteen codes in both fields. Each field is paired with a different code in the other field, so that a swapped field select or a wrong table entry shows up as a wrong window count. A sweep over all 32 slot indices, with the two fields set to lengths 4 and 8, locates both edges of the upper-field range. The start sources are tried one at a time: a software start with the power bit clear, a software start, a trigger edge, and a trigger held high. These separate an edge-detected trigger from a level-sensitive one. Repeat mode is run with and without `seq_mode` and with enable cleared mid-window. This shows that automatic restart depends on all three conditions.

// File: rtl/adc_st_pkg.sv
package adc_st_pkg;

    localparam int CODE_W = 4;
    localparam int CNT_W  = 10;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SAMPLE = 2'd1,
        ST_PULSE  = 2'd2,
        ST_WAIT   = 2'd3
    } tmr_state_e;

    typedef struct packed {
        logic [CODE_W-1:0] code_hi;
        logic [CODE_W-1:0] code_lo;
        logic              repeat_en;
        logic              pwr_on;
        logic              enable;
        logic              start;
    } ctl_word_t;

    typedef struct packed {
        tmr_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic              trig_prev;
    } tmr_t;

    // Window length in clock cycles for a 4-bit code; codes beyond 10 use the longest length.
    function automatic logic [CNT_W-1:0] code_to_len(input logic [CODE_W-1:0] c);
        logic [CNT_W-1:0] base;
        logic [CODE_W-1:0] step;
        if (c > CODE_W'(10)) begin
            code_to_len = CNT_W'(512);
        end else if (c < CODE_W'(4)) begin
            code_to_len = CNT_W'(4) << c;
        end else begin
            step = (c - CODE_W'(4)) >> 1;
            base = CNT_W'(64) << step;
            code_to_len = c[0] ? (base + (base >> 1)) : base;
        end
    endfunction

endpackage

// File: rtl/adc_st_regs.sv
module adc_st_regs
    import adc_st_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [15:0] wr_data,
    output ctl_word_t   ctl,
    output logic [15:0] rd_data
);

    ctl_word_t ctl_d, ctl_q;
    logic      unused_rsvd;

    assign unused_rsvd = ^{wr_data[6:5], wr_data[3:2]};

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.start = 1'b0;
        if (wr_en) begin
            if (!ctl_q.enable) begin
                ctl_d.code_hi   = wr_data[15:12];
                ctl_d.code_lo   = wr_data[11:8];
                ctl_d.repeat_en = wr_data[7];
                ctl_d.pwr_on    = wr_data[4];
            end
            ctl_d.enable = wr_data[1];
            ctl_d.start  = wr_data[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign ctl     = ctl_q;
    assign rd_data = {ctl_q.code_hi, ctl_q.code_lo, ctl_q.repeat_en, 2'b00,
                      ctl_q.pwr_on, 2'b00, ctl_q.enable, ctl_q.start};

endmodule

// File: rtl/adc_st_lensel.sv
module adc_st_lensel
    import adc_st_pkg::*;
#(
    parameter int SLOT_W   = 5,
    parameter int HI_FIRST = 8,
    parameter int HI_LAST  = 23
) (
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic [CODE_W-1:0] code_hi,
    input  logic [CODE_W-1:0] code_lo,
    output logic [CNT_W-1:0]  win_len
);

    logic in_hi_range;
    logic [CODE_W-1:0] code_sel;

    always_comb begin
        in_hi_range = (slot_idx >= SLOT_W'(HI_FIRST)) && (slot_idx <= SLOT_W'(HI_LAST));
        code_sel    = in_hi_range ? code_hi : code_lo;
        win_len     = code_to_len(code_sel);
    end

endmodule

// File: rtl/adc_st_timer.sv
module adc_st_timer
    import adc_st_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_ok,
    input  logic             sw_start,
    input  logic             trig_in,
    input  logic             auto_ok,
    input  logic             conv_done,
    input  logic [CNT_W-1:0] win_len,
    output logic             sample_win,
    output logic             conv_start
);

    tmr_t t_d, t_q;
    logic trig_rise;

    always_comb begin
        t_d           = t_q;
        t_d.trig_prev = trig_in;
        trig_rise     = trig_in && !t_q.trig_prev;
        unique case (t_q.st)
            ST_IDLE: begin
                if (run_ok && (sw_start || trig_rise)) begin
                    t_d.st  = ST_SAMPLE;
                    t_d.cnt = win_len - CNT_W'(1);
                end
            end
            ST_SAMPLE: begin
                if (t_q.cnt == '0) begin
                    t_d.st = ST_PULSE;
                end else begin
                    t_d.cnt = t_q.cnt - CNT_W'(1);
                end
            end
            ST_PULSE: begin
                t_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (conv_done) begin
                    if (run_ok && auto_ok) begin
                        t_d.st  = ST_SAMPLE;
                        t_d.cnt = win_len - CNT_W'(1);
                    end else begin
                        t_d.st = ST_IDLE;
                    end
                end
            end
            default: t_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            t_q <= '{st: ST_IDLE, cnt: '0, trig_prev: 1'b0};
        end else begin
            t_q <= t_d;
        end
    end

    assign sample_win = (t_q.st == ST_SAMPLE);
    assign conv_start = (t_q.st == ST_PULSE);

endmodule

// File: rtl/adc_sample_ctrl.sv
module adc_sample_ctrl
    import adc_st_pkg::*;
#(
    parameter int SLOT_W   = 5,
    parameter int HI_FIRST = 8,
    parameter int HI_LAST  = 23
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [15:0]       wr_data,
    output logic [15:0]       rd_data,
    input  logic              trig_in,
    input  logic              seq_mode,
    input  logic [SLOT_W-1:0] slot_idx,
    input  logic              conv_done,
    output logic              sample_win,
    output logic              conv_start
);

    ctl_word_t        ctl;
    logic [CNT_W-1:0] win_len;
    logic             run_ok;
    logic             auto_ok;

    adc_st_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctl     (ctl),
        .rd_data (rd_data)
    );

    adc_st_lensel #(
        .SLOT_W   (SLOT_W),
        .HI_FIRST (HI_FIRST),
        .HI_LAST  (HI_LAST)
    ) u_lensel (
        .slot_idx (slot_idx),
        .code_hi  (ctl.code_hi),
        .code_lo  (ctl.code_lo),
        .win_len  (win_len)
    );

    assign run_ok  = ctl.pwr_on && ctl.enable;
    assign auto_ok = ctl.repeat_en && seq_mode;

    adc_st_timer u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_ok     (run_ok),
        .sw_start   (ctl.start),
        .trig_in    (trig_in),
        .auto_ok    (auto_ok),
        .conv_done  (conv_done),
        .win_len    (win_len),
        .sample_win (sample_win),
        .conv_start (conv_start)
    );

endmodule

// File: rtl/adc_sample_ctrl_chk.sv
module adc_sample_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic [15:0] rd_data,
    input logic        seq_mode,
    input logic        conv_done,
    input logic        sample_win,
    input logic        conv_start
);

    logic [10:0] win_cnt_q;
    logic        pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_cnt_q <= '0;
            pend_q    <= 1'b0;
        end else begin
            win_cnt_q <= sample_win ? win_cnt_q + 11'd1 : 11'd0;
            if (conv_start) begin
                pend_q <= 1'b1;
            end else if (conv_done) begin
                pend_q <= 1'b0;
            end
        end
    end

    // R2: every window lies between the shortest and longest lengths
    a_r2_len_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_win) |-> (win_cnt_q >= 11'd4 && win_cnt_q <= 11'd512));

    // R4: start pulse directly follows the window and lasts one cycle
    a_r4_pulse_after_win: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sample_win) |-> conv_start);

    a_r4_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> (!conv_start && !sample_win));

    // R4: no window opens while a conversion result is outstanding
    a_r4_wait_done: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_win) |-> !pend_q);

    // R5: locked fields keep their value across a write while enabled
    a_r5_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && rd_data[1]) |=> $stable(rd_data[15:4]));

    // R7: a window opens only with power and enable set
    a_r7_needs_on_en: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sample_win) |-> $past(rd_data[4] && rd_data[1]));

    // R9: repeat mode restarts right after conversion done
    a_r9_auto_restart: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && pend_q && seq_mode && rd_data[7] && rd_data[4] && rd_data[1])
        |=> sample_win);

    // R10: with enable clear, conversion done returns to idle
    a_r10_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done && pend_q && !rd_data[1]) |=> !sample_win);

endmodule

bind adc_sample_ctrl adc_sample_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_data    (rd_data),
    .seq_mode   (seq_mode),
    .conv_done  (conv_done),
    .sample_win (sample_win),
    .conv_start (conv_start)
);

// File: tb/sim_adc_sample_ctrl.sv
module sim_adc_sample_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic [15:0] rd_data;
    logic        trig_in = 1'b0;
    logic        seq_mode = 1'b0;
    logic [4:0]  slot_idx = '0;
    logic        conv_done = 1'b0;
    logic        sample_win;
    logic        conv_start;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    adc_sample_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .rd_data    (rd_data),
        .trig_in    (trig_in),
        .seq_mode   (seq_mode),
        .slot_idx   (slot_idx),
        .conv_done  (conv_done),
        .sample_win (sample_win),
        .conv_start (conv_start)
    );

    function automatic int exp_len(input int c);
        case (c)
            0: return 4;     1: return 8;     2: return 16;   3: return 32;
            4: return 64;    5: return 96;    6: return 128;  7: return 192;
            8: return 256;   9: return 384;   default: return 512;
        endcase
    endfunction

    function automatic logic [15:0] mk(input int hi, input int lo, input bit rep,
                                       input bit on, input bit en, input bit go);
        return {hi[3:0], lo[3:0], rep, 2'b00, on, 2'b00, en, go};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run_window(output int len, output bit pulse);
        int w = 0;
        len = 0;
        while (!sample_win && w < 2000) begin @(negedge clk); w++; end
        while (sample_win && len < 2000) begin len++; @(negedge clk); end
        pulse = conv_start;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
    endtask

    task automatic quiet(input int n, input string req);
        int seen = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (sample_win) seen++;
        end
        chk(seen == 0, req, seen, 0);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int len;
        bit pulse;
        int first;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rd_data == 16'h0000, "R1 rd_data", rd_data, 0);
        chk(!sample_win && !conv_start, "R1 outputs", {sample_win, conv_start}, 0);

        // R6 reserved bits read zero
        wr(16'hFFFC);
        chk(rd_data == 16'hFF90, "R6 reserved", rd_data, 16'hFF90);
        wr(16'h0000);

        // R2 code sweep over both fields; R4 window and pulse
        for (int c = 0; c < 16; c++) begin
            for (int f = 0; f < 2; f++) begin
                slot_idx = (f == 0) ? 5'd8 : 5'd0;
                if (f == 0) wr(mk(c, 15 - c, 0, 1, 1, 1));
                else        wr(mk(15 - c, c, 0, 1, 1, 1));
                run_window(len, pulse);
                chk(len == exp_len(c), "R2 length", len, exp_len(c));
                chk(pulse, "R4 pulse after window", pulse, 1);
                @(negedge clk);
                chk(!conv_start && !sample_win, "R4 pulse one cycle", conv_start, 0);
                done_pulse();
                wr(mk(0, 0, 0, 1, 0, 0));
            end
        end

        // R3 slot sweep: upper field 4 cycles, lower field 8 cycles
        for (int s = 0; s < 32; s++) begin
            int e;
            slot_idx = s[4:0];
            e = (s >= 8 && s <= 23) ? 4 : 8;
            wr(mk(0, 1, 0, 1, 1, 1));
            run_window(len, pulse);
            chk(len == e, "R3 slot select", len, e);
            done_pulse();
            wr(mk(0, 1, 0, 1, 0, 0));
        end

        // R7 start honoured in same write as enable; self-clears
        slot_idx = 5'd0;
        wr(mk(0, 1, 0, 1, 1, 1));
        chk(rd_data[0] == 1'b1 && !sample_win, "R7 start visible", rd_data[0], 1);
        @(negedge clk);
        chk(rd_data[0] == 1'b0, "R7 start cleared", rd_data[0], 0);
        chk(sample_win == 1'b1, "R7 window opens", sample_win, 1);
        run_window(len, pulse);
        // R4 start request during wait is discarded
        wr(mk(0, 1, 0, 1, 1, 1));
        quiet(10, "R4 no window before done");
        done_pulse();
        quiet(10, "R4 start while busy dropped");
        wr(mk(0, 1, 0, 1, 0, 0));

        // R7 start ignored with power off
        wr(mk(0, 1, 0, 0, 0, 0));
        wr(mk(0, 1, 0, 0, 1, 1));
        quiet(10, "R7 power off no window");
        chk(rd_data[0] == 1'b0, "R7 start self clear", rd_data[0], 0);
        wr(mk(0, 1, 0, 1, 0, 0));

        // R5 lock while enabled
        wr(mk(2, 3, 0, 1, 1, 0));
        wr(mk(9, 9, 1, 0, 1, 0));
        chk(rd_data == mk(2, 3, 0, 1, 1, 0), "R5 locked fields", rd_data, mk(2, 3, 0, 1, 1, 0));
        wr(mk(9, 9, 1, 0, 0, 0));
        chk(rd_data == mk(2, 3, 0, 1, 0, 0), "R5 enable writable", rd_data, mk(2, 3, 0, 1, 0, 0));

        // R8 trigger edge
        wr(mk(0, 1, 0, 1, 1, 0));
        quiet(5, "R8 idle without trigger");
        @(negedge clk);
        trig_in = 1'b1;
        run_window(len, pulse);
        chk(len == 8, "R8 trigger window", len, 8);
        done_pulse();
        quiet(20, "R8 held level no restart");
        @(negedge clk);
        trig_in = 1'b0;
        @(negedge clk);
        trig_in = 1'b1;
        run_window(len, pulse);
        chk(len == 8, "R8 second edge", len, 8);
        done_pulse();
        trig_in = 1'b0;
        wr(mk(0, 1, 0, 1, 0, 0));

        // R9 repeat with sequence mode
        seq_mode = 1'b1;
        wr(mk(0, 2, 1, 1, 1, 1));
        run_window(len, pulse);
        first = len;
        done_pulse();
        chk(sample_win == 1'b1, "R9 auto restart", sample_win, 1);
        run_window(len, pulse);
        chk(first == 16 && len == 16, "R9 restart length", len, 16);
        // R10 clear enable during running conversion
        done_pulse();
        chk(sample_win == 1'b1, "R9 third window", sample_win, 1);
        wr(mk(0, 2, 1, 1, 0, 0));
        run_window(len, pulse);
        done_pulse();
        quiet(20, "R10 stop after disable");

        // R9 repeat bit without sequence mode
        seq_mode = 1'b0;
        wr(mk(0, 2, 1, 1, 1, 1));
        run_window(len, pulse);
        done_pulse();
        quiet(20, "R9 no restart without seq_mode");
        wr(mk(0, 2, 1, 1, 0, 0));

        // R9 sequence mode without repeat bit
        seq_mode = 1'b1;
        wr(mk(0, 2, 0, 1, 1, 1));
        run_window(len, pulse);
        done_pulse();
        quiet(20, "R9 no restart without repeat bit");

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule